// File: doc/BRIEF.md
# Bidirectional Byte Buffer with Parity Generation and Checking

This block passes a byte between two ports, A and B, in either direction. It also generates parity on outgoing data and checks parity on incoming data. A direction input chooses the path. When it is high, A data goes out on B. When it is low, B data goes out on A. An active-low enable releases every driver when it is high, so the block can share a bus with other agents. Each tri-state pin appears as three signals: an input value, an output value and a drive enable. Pad logic outside the block combines them.

A single parity pin changes role with the direction. On transmit it carries a parity bit generated from the A byte. On receive it brings in the parity bit that arrived with the B byte. A select input chooses even or odd parity for both roles. An active-low error flag reports a received byte whose ones count, together with the incoming parity bit, breaks the selected rule. The block has no clock and no state. Every output follows its inputs through gates only.

Top module: `xcvr_par`

## Requirements
- R1: With `dir_tx`=1 and `oe_n`=0, `b_oe`=1 and `a_oe`=0, so the A byte is driven onto B.
- R2: With `dir_tx`=0 and `oe_n`=0, `a_oe`=1 and `b_oe`=0, so the B byte is driven onto A.
- R3: With `oe_n`=1, `a_oe`, `b_oe` and `par_oe` are all 0, whatever the other inputs are.
- R4: With `odd_sel`=0 (even parity), `par_out` is 1 exactly when `a_in` holds an odd number of ones.
- R5: With `odd_sel`=1 (odd parity), `par_out` is 1 exactly when `a_in` holds an even number of ones, so that the byte and the parity bit together hold an odd number of ones.
- R6: `par_oe` is 1 only when `dir_tx`=1 and `oe_n`=0. In every other case it is 0.
- R7: On receive (`dir_tx`=0, `oe_n`=0) with `odd_sel`=0, `err_n` is 1 when the ones in `b_in` plus `par_in` add up to an even number, and 0 otherwise.
- R8: On receive with `odd_sel`=1, `err_n` is 1 when the ones in `b_in` plus `par_in` add up to an odd number, and 0 otherwise.
- R9: When `dir_tx`=1 or `oe_n`=1, `err_n` is 1, whatever the values of `b_in` and `par_in`.
- R10: The data paths do not invert: `b_out` always equals `a_in` and `a_out` always equals `b_in`, bit for bit. Only the drive enables depend on the direction and enable inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 8 | Value read from the A-side pins |
| a_out | output | 8 | Value driven onto the A-side pins |
| a_oe | output | 1 | Drive enable for the A-side pins |
| b_in | input | 8 | Value read from the B-side pins |
| b_out | output | 8 | Value driven onto the B-side pins |
| b_oe | output | 1 | Drive enable for the B-side pins |
| par_in | input | 1 | Value read from the parity pin (received parity) |
| par_out | output | 1 | Generated parity driven onto the parity pin |
| par_oe | output | 1 | Drive enable for the parity pin |
| dir_tx | input | 1 | 1: A to B (transmit), 0: B to A (receive) |
| oe_n | input | 1 | Active-low enable; 1 releases all drivers |
| odd_sel | input | 1 | 0: even parity, 1: odd parity |
| err_n | output | 1 | Active-low parity error on received data |

## Verification
The bench runs every byte value under each combination of direction, enable, parity select and incoming parity bit. This sweep catches a parity tree that drops or repeats one bit, because such a design flips the result for half of all bytes. It also catches a select input applied with the wrong polarity, which swaps the even and odd results everywhere. Random B bytes that differ from the A byte show whether the checker reads the wrong port. Disabled and transmit cases with an incoming parity that does not match check that the error flag stays quiet, and that the parity pin never drives while the block is receiving or disabled.

// File: rtl/xcvr_par_pkg.sv
package xcvr_par_pkg;
    localparam int unsigned BUS_W = 8;

    typedef struct packed {
        logic a_drv;
        logic b_drv;
        logic p_drv;
        logic chk_on;
    } xcvr_ctl_t;
endpackage

// File: rtl/xcvr_par_tree.sv
module xcvr_par_tree #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] d,
    output logic         p
);
    localparam int unsigned LVL    = (W > 1) ? $clog2(W) : 1;
    localparam int unsigned LEAVES = 1 << LVL;
    localparam int unsigned NODES  = 2 * LEAVES - 1;

    logic [LEAVES-1:0] pad;
    logic [NODES-1:0]  tree;

    // balanced XOR tree: leaves at the top of the heap, root at index 0
    always_comb begin
        pad = '0;
        pad[W-1:0] = d;
        tree = '0;
        for (int i = 0; i < int'(LEAVES); i++) begin
            tree[LEAVES-1+i] = pad[i];
        end
        for (int k = int'(LEAVES) - 2; k >= 0; k--) begin
            tree[k] = tree[2*k+1] ^ tree[2*k+2];
        end
    end

    assign p = tree[0];
endmodule

// File: rtl/xcvr_par_route.sv
module xcvr_par_route
    import xcvr_par_pkg::*;
(
    input  logic      dir_tx,
    input  logic      oe_n,
    output xcvr_ctl_t ctl
);
    xcvr_ctl_t ctl_d;

    always_comb begin
        ctl_d        = '0;
        ctl_d.a_drv  = !oe_n && !dir_tx;
        ctl_d.b_drv  = !oe_n &&  dir_tx;
        ctl_d.p_drv  = !oe_n &&  dir_tx;
        ctl_d.chk_on = !oe_n && !dir_tx;
    end

    assign ctl = ctl_d;
endmodule

// File: rtl/xcvr_par_check.sv
module xcvr_par_check #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] b_in,
    input  logic         par_in,
    input  logic         odd_sel,
    input  logic         chk_on,
    output logic         err_n
);
    logic b_par;
    logic err_n_d;

    xcvr_par_tree #(.W(W)) u_tree (
        .d (b_in),
        .p (b_par)
    );

    // the nine-bit total must have the parity named by odd_sel
    always_comb begin
        err_n_d = 1'b1;
        if (chk_on) begin
            err_n_d = ((b_par ^ par_in) == odd_sel);
        end
    end

    assign err_n = err_n_d;
endmodule

// File: rtl/xcvr_par.sv
module xcvr_par
    import xcvr_par_pkg::*;
#(
    parameter int unsigned WIDTH = BUS_W
) (
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic             par_in,
    output logic             par_out,
    output logic             par_oe,
    input  logic             dir_tx,
    input  logic             oe_n,
    input  logic             odd_sel,
    output logic             err_n
);
    xcvr_ctl_t ctl;
    logic      a_par;

    xcvr_par_route u_route (
        .dir_tx (dir_tx),
        .oe_n   (oe_n),
        .ctl    (ctl)
    );

    xcvr_par_tree #(.W(WIDTH)) u_gen (
        .d (a_in),
        .p (a_par)
    );

    xcvr_par_check #(.W(WIDTH)) u_chk_path (
        .b_in    (b_in),
        .par_in  (par_in),
        .odd_sel (odd_sel),
        .chk_on  (ctl.chk_on),
        .err_n   (err_n)
    );

    assign a_out   = b_in;
    assign b_out   = a_in;
    assign a_oe    = ctl.a_drv;
    assign b_oe    = ctl.b_drv;
    assign par_oe  = ctl.p_drv;
    assign par_out = a_par ^ odd_sel;
endmodule

// File: rtl/xcvr_par_chk.sv
module xcvr_par_chk #(
    parameter int unsigned W = 8
) (
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic         par_in,
    input logic         par_out,
    input logic         par_oe,
    input logic         dir_tx,
    input logic         oe_n,
    input logic         odd_sel,
    input logic         err_n
);
    logic known;
    assign known = !$isunknown({a_in, b_in, par_in, dir_tx, oe_n, odd_sel});

    always_comb begin
        if (known) begin
            // R1
            tx_route_chk: assert (!(dir_tx && !oe_n) || (b_oe && !a_oe));
            // R2
            rx_route_chk: assert (!(!dir_tx && !oe_n) || (a_oe && !b_oe));
            // R3
            off_chk: assert (!oe_n || (!a_oe && !b_oe && !par_oe));
            // R4
            even_gen_chk: assert (odd_sel || (par_out == ($countones(a_in) % 2 == 1)));
            // R5
            odd_gen_chk: assert (!odd_sel || (par_out == ($countones(a_in) % 2 == 0)));
            // R6
            par_drv_chk: assert (!par_oe || (dir_tx && !oe_n));
            // R7
            even_rcv_chk: assert (dir_tx || oe_n || odd_sel ||
                                  (err_n == (($countones(b_in) + int'(par_in)) % 2 == 0)));
            // R8
            odd_rcv_chk: assert (dir_tx || oe_n || !odd_sel ||
                                 (err_n == (($countones(b_in) + int'(par_in)) % 2 == 1)));
            // R9
            err_idle_chk: assert (!(dir_tx || oe_n) || err_n);
            // R10
            mirror_chk: assert ((a_out == b_in) && (b_out == a_in));
        end
    end
endmodule

bind xcvr_par xcvr_par_chk #(.W(WIDTH)) u_prop (
    .a_in    (a_in),
    .a_out   (a_out),
    .a_oe    (a_oe),
    .b_in    (b_in),
    .b_out   (b_out),
    .b_oe    (b_oe),
    .par_in  (par_in),
    .par_out (par_out),
    .par_oe  (par_oe),
    .dir_tx  (dir_tx),
    .oe_n    (oe_n),
    .odd_sel (odd_sel),
    .err_n   (err_n)
);

// File: tb/xcvr_par_tb.sv
module xcvr_par_tb;
    localparam int W = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic a_oe, b_oe, par_in, par_out, par_oe, dir_tx, oe_n, odd_sel, err_n;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    xcvr_par #(.WIDTH(W)) u_dut (
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
        .dir_tx(dir_tx), .oe_n(oe_n), .odd_sel(odd_sel), .err_n(err_n)
    );

    function automatic int ones(input logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic logic exp_par(input logic [W-1:0] v, input logic sel);
        logic odd_cnt = (ones(v) % 2) == 1;
        return sel ? !odd_cnt : odd_cnt;
    endfunction

    function automatic logic exp_err_n(input logic [W-1:0] v, input logic p,
                                       input logic sel, input logic dir, input logic oe);
        int tot;
        if (dir || oe) return 1'b1;
        tot = ones(v) + int'(p);
        return sel ? (tot % 2 == 1) : (tot % 2 == 0);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (a=%0h b=%0h p=%0b dir=%0b oe_n=%0b sel=%0b)",
                     req, act, exp, a_in, b_in, par_in, dir_tx, oe_n, odd_sel);
        end
    endtask

    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input logic p,
                       input logic dir, input logic oe, input logic sel);
        logic ep, ee;
        @(posedge clk);
        a_in = a; b_in = b; par_in = p; dir_tx = dir; oe_n = oe; odd_sel = sel;
        @(negedge clk);
        ep = exp_par(a, sel);
        ee = exp_err_n(b, p, sel, dir, oe);
        if (!oe && dir)  chk(b_oe && !a_oe, "R1", int'({a_oe, b_oe}), 1);
        if (!oe && !dir) chk(a_oe && !b_oe, "R2", int'({a_oe, b_oe}), 2);
        if (oe)          chk(!a_oe && !b_oe && !par_oe, "R3", int'({a_oe, b_oe, par_oe}), 0);
        if (!sel) chk(par_out == ep, "R4", int'(par_out), int'(ep));
        else      chk(par_out == ep, "R5", int'(par_out), int'(ep));
        chk(par_oe == (dir && !oe), "R6", int'(par_oe), int'(dir && !oe));
        if (dir || oe)  chk(err_n == ee, "R9", int'(err_n), int'(ee));
        else if (!sel)  chk(err_n == ee, "R7", int'(err_n), int'(ee));
        else            chk(err_n == ee, "R8", int'(err_n), int'(ee));
        chk((a_out == b) && (b_out == a), "R10", int'({a_out, b_out}), int'({b, a}));
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0657));
        // idle: all drivers released, no error flagged (R3, R9)
        a_in = 8'h00; b_in = 8'h00; par_in = 1'b1; dir_tx = 1'b0; oe_n = 1'b1; odd_sel = 1'b0;
        @(negedge clk);
        chk(!a_oe && !b_oe && !par_oe, "R3", int'({a_oe, b_oe, par_oe}), 0);
        chk(err_n == 1'b1, "R9", int'(err_n), 1);

        // directed corners: all-zero and all-one bytes, single-bit bytes
        for (int m = 0; m < 16; m++) begin
            run(8'h00, 8'h00, m[0], m[1], m[2], m[3]);
            run(8'hFF, 8'hFF, m[0], m[1], m[2], m[3]);
            run(8'h80, 8'h01, m[0], m[1], m[2], m[3]);
        end

        // full sweep of every byte under each control combination (R1..R10)
        for (int m = 0; m < 16; m++) begin
            for (int v = 0; v < 256; v++) begin
                run(W'(v), W'(v), m[0], m[1], m[2], m[3]);
            end
        end

        // random: A and B bytes differ, so checker must read B, generator A
        for (int n = 0; n < 3000; n++) begin
            run(W'($urandom), W'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule